// File: doc/BRIEF.md
# Lookup Table Refill Descriptor Engine

This block is a bus master that fills a two-dimensional page lookup table from linked descriptors held in memory. It holds several independent walkers. Software starts a walker by writing a descriptor address into that walker's start register. The walker then reads the four-word descriptor. The descriptor gives the rectangle of table slots, the target table, a data pointer and the address of the next descriptor. The walker then reads one 32-bit page address per slot and writes it into the table in row-major order.

The walker follows the chain until a next pointer of zero and then reports completion. All walkers share one memory read port, with a single read outstanding at a time. They also share one table write port and one interrupt status register, in which each walker owns an 8-bit field. A rectangle that does not fit the table, or a failed memory read, stops the walker in a fault state until software clears it.

Top module: `lut_refill_dma`

## Requirements
- R1: After reset, each walker's status register (word address 8+n) reads 1, with bit 0 = ready and bit 1 = fault. The interrupt status (address 1) reads 0 and the interrupt line is low. The interrupt enable (address 2) reads 0x7E in the byte of every implemented walker. The hardware-info word (address 0) carries the walker count in bits [28:24] and the table count in bits [20:16].
- R2: Writing a nonzero value to a walker's start register (address 4+n) while that walker is ready starts a walk. The walk begins at that address with bits [3:0] forced to zero. A descriptor is four words in this order: +0 next pointer, +4 area {y1[31:24], x1[23:16], y0[15:8], x0[7:0]}, +8 control (bit 0 start, bits [12:8] table id), +12 data pointer.
- R3: A descriptor covers (x1-x0+1)*(y1-y0+1) slots. The slots are read as consecutive words from the data pointer, with bits [3:0] cleared. Each word is written to table id (x, y), with x running fastest.
- R4: The walker follows next pointers until one is zero in bits [31:4]. It then sets the last-done bit (bit 1 of its field) and becomes ready again.
- R5: Each fully fetched descriptor sets the fetched bit (bit 0 of the walker's field).
- R6: A descriptor with its start bit clear writes no entries, and the walk moves on to its next pointer.
- R7: A rectangle with x0>x1, y0>y1, x1 at or beyond the table width, y1 at or beyond the table height, or a table id at or above the table count sets the range bit (bit 2). It also sets fault, clears ready, writes no entries and ends the walk.
- R8: A memory read returned with an error sets the bus-error bit (bit 3), sets fault, clears ready and ends the walk.
- R9: A nonzero start write while the walker is not ready is ignored. A zero write aborts any walk, clears fault and leaves the walker ready on the next cycle.
- R10: Walker n owns bits [8n+7:8n] of the interrupt status, and bits 4 to 7 of each field stay 0. A write to the status register clears the bits written as 1. An event arriving in the same cycle wins over the clear.
- R11: The interrupt line is high exactly when some status bit and its enable bit are both set. The enable register can be read and written.
- R12: At most one memory read is outstanding. When walkers compete, the lowest-numbered one is granted. Every read address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| mem_req | output | 1 | Single-cycle memory read issue |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | 32 | Memory read response data |
| mem_rerr | input | 1 | Memory read response error |
| lut_we | output | 1 | Table entry write strobe |
| lut_sel | output | LIDW | Table id |
| lut_x | output | XW | Slot column |
| lut_y | output | YW | Slot row |
| lut_data | output | 32 | Page address written |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples it, so ready, fault and abort results can be read back right after that edge. A table write appears in the same cycle as the memory response carrying its data. A walker event reaches the interrupt status one edge after the walker changes state. The bench therefore polls each walker's status once per cycle until ready or fault shows, then waits two more cycles before reading the interrupt status and the line. All outputs are sampled one time unit after the falling edge. Table writes are logged at the rising edge, so order and contents are compared against values worked out from the descriptors.

// File: rtl/lut_refill_pkg.sv
package lut_refill_pkg;

   typedef enum logic [2:0] {
      W_IDLE  = 3'd0,
      W_DREQ  = 3'd1,
      W_DWAIT = 3'd2,
      W_PREQ  = 3'd3,
      W_PWAIT = 3'd4,
      W_FAULT = 3'd5
   } walk_state_e;

   // event bit positions inside a walker's interrupt byte
   localparam int EV_FETCH = 0;
   localparam int EV_LAST  = 1;
   localparam int EV_RANGE = 2;
   localparam int EV_BUS   = 3;
   localparam int EV_W     = 4;

   // register word addresses
   localparam logic [3:0] RA_INFO  = 4'd0;
   localparam logic [3:0] RA_ISTAT = 4'd1;
   localparam logic [3:0] RA_IEN   = 4'd2;
   localparam logic [1:0] RG_DESC  = 2'd1;
   localparam logic [1:0] RG_STAT  = 2'd2;

   localparam logic [7:0] IEN_RESET = 8'h7E;
   localparam int         MAX_ENG   = 4;

endpackage

// File: rtl/lut_refill_walker.sv
module lut_refill_walker
   import lut_refill_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LUT_W   = 256,
   parameter int LUT_H   = 128,
   parameter int NUM_LUT = 2,
   parameter int XW      = 8,
   parameter int YW      = 7,
   parameter int LIDW    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [31:0]       start_addr_i,
   output logic              want_o,
   output logic [ADDR_W-1:0] addr_o,
   input  logic              grant_i,
   input  logic              rvalid_i,
   input  logic [31:0]       rdata_i,
   input  logic              rerr_i,
   output logic              ready_o,
   output logic              fault_o,
   output logic [EV_W-1:0]   ev_o,
   output logic              lut_we_o,
   output logic [LIDW-1:0]   lut_id_o,
   output logic [XW-1:0]     lut_x_o,
   output logic [YW-1:0]     lut_y_o,
   output logic [31:0]       lut_data_o
);

   localparam logic [31:0] LW = 32'(LUT_W);
   localparam logic [31:0] LH = 32'(LUT_H);
   localparam logic [31:0] LN = 32'(NUM_LUT);

   walk_state_e       state;
   logic [ADDR_W-5:0] ptr_q;
   logic [1:0]        widx_q;
   logic [31:0]       nxt_q, area_q, ctrl_q;
   logic [ADDR_W-1:0] daddr_q;
   logic [7:0]        cx_q, cy_q;
   logic              fault_q;
   logic [EV_W-1:0]   ev_q;

   logic [7:0] ax0, ay0, ax1, ay1;
   logic       area_bad, chain_end, row_end, col_end;

   assign ax0 = area_q[7:0];
   assign ay0 = area_q[15:8];
   assign ax1 = area_q[23:16];
   assign ay1 = area_q[31:24];

   assign area_bad = (ax0 > ax1) || (ay0 > ay1) ||
                     ({24'd0, ax1} >= LW) || ({24'd0, ay1} >= LH) ||
                     ({27'd0, ctrl_q[12:8]} >= LN);
   assign chain_end = (nxt_q[31:4] == 28'd0);
   assign col_end   = (cx_q == ax1);
   assign row_end   = (cy_q == ay1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= W_IDLE;
         ptr_q   <= '0;
         widx_q  <= '0;
         nxt_q   <= '0;
         area_q  <= '0;
         ctrl_q  <= '0;
         daddr_q <= '0;
         cx_q    <= '0;
         cy_q    <= '0;
         fault_q <= 1'b0;
         ev_q    <= '0;
      end else begin
         ev_q <= '0;
         if (abort_i) begin
            state   <= W_IDLE;
            fault_q <= 1'b0;
         end else begin
            case (state)
               W_IDLE: begin
                  if (start_i && !fault_q) begin
                     ptr_q  <= start_addr_i[ADDR_W-1:4];
                     widx_q <= 2'd0;
                     state  <= W_DREQ;
                  end
               end
               W_DREQ: if (grant_i) state <= W_DWAIT;
               W_DWAIT: begin
                  if (rvalid_i) begin
                     if (rerr_i) begin
                        fault_q      <= 1'b1;
                        ev_q[EV_BUS] <= 1'b1;
                        state        <= W_FAULT;
                     end else begin
                        case (widx_q)
                           2'd0: nxt_q  <= rdata_i;
                           2'd1: area_q <= rdata_i;
                           2'd2: ctrl_q <= rdata_i;
                           default: ;
                        endcase
                        if (widx_q == 2'd3) begin
                           ev_q[EV_FETCH] <= 1'b1;
                           if (area_bad) begin
                              fault_q        <= 1'b1;
                              ev_q[EV_RANGE] <= 1'b1;
                              state          <= W_FAULT;
                           end else if (!ctrl_q[0]) begin
                              if (chain_end) begin
                                 ev_q[EV_LAST] <= 1'b1;
                                 state         <= W_IDLE;
                              end else begin
                                 ptr_q  <= nxt_q[ADDR_W-1:4];
                                 widx_q <= 2'd0;
                                 state  <= W_DREQ;
                              end
                           end else begin
                              cx_q    <= ax0;
                              cy_q    <= ay0;
                              daddr_q <= {rdata_i[ADDR_W-1:4], 4'h0};
                              state   <= W_PREQ;
                           end
                        end else begin
                           widx_q <= widx_q + 2'd1;
                           state  <= W_DREQ;
                        end
                     end
                  end
               end
               W_PREQ: if (grant_i) state <= W_PWAIT;
               W_PWAIT: begin
                  if (rvalid_i) begin
                     if (rerr_i) begin
                        fault_q      <= 1'b1;
                        ev_q[EV_BUS] <= 1'b1;
                        state        <= W_FAULT;
                     end else begin
                        daddr_q <= daddr_q + ADDR_W'(4);
                        state   <= W_PREQ;
                        if (col_end) begin
                           cx_q <= ax0;
                           cy_q <= cy_q + 8'd1;
                           if (row_end) begin
                              if (chain_end) begin
                                 ev_q[EV_LAST] <= 1'b1;
                                 state         <= W_IDLE;
                              end else begin
                                 ptr_q  <= nxt_q[ADDR_W-1:4];
                                 widx_q <= 2'd0;
                                 state  <= W_DREQ;
                              end
                           end
                        end else begin
                           cx_q <= cx_q + 8'd1;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign want_o     = (state == W_DREQ) || (state == W_PREQ);
   assign addr_o     = (state == W_DREQ) ? {ptr_q, widx_q, 2'b00} : daddr_q;
   assign ready_o    = (state == W_IDLE) && !fault_q;
   assign fault_o    = fault_q;
   assign ev_o       = ev_q;
   assign lut_we_o   = (state == W_PWAIT) && rvalid_i && !rerr_i;
   assign lut_id_o   = ctrl_q[8 +: LIDW];
   assign lut_x_o    = cx_q[XW-1:0];
   assign lut_y_o    = cy_q[YW-1:0];
   assign lut_data_o = rdata_i;

endmodule

// File: rtl/lut_refill_arb.sv
module lut_refill_arb #(
   parameter int N      = 2,
   parameter int ADDR_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N-1:0]              want_i,
   input  logic [N-1:0][ADDR_W-1:0]  addr_i,
   input  logic                      mem_rvalid_i,
   output logic [N-1:0]              grant_o,
   output logic [N-1:0]              resp_o,
   output logic                      mem_req_o,
   output logic [ADDR_W-1:0]         mem_addr_o
);

   logic [N-1:0] own_q;
   logic         busy;

   assign busy = |own_q;

   // fixed priority, lowest index first, only when the port is free
   always_comb begin
      grant_o    = '0;
      mem_addr_o = '0;
      if (!busy) begin
         for (int i = N - 1; i >= 0; i--) begin
            if (want_i[i]) begin
               grant_o    = '0;
               grant_o[i] = 1'b1;
               mem_addr_o = addr_i[i];
            end
         end
      end
   end

   assign mem_req_o = |grant_o;
   assign resp_o    = own_q & {N{mem_rvalid_i}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              own_q <= '0;
      else if (mem_req_o)      own_q <= grant_o;
      else if (mem_rvalid_i)   own_q <= '0;
   end

endmodule

// File: rtl/lut_refill_irq.sv
module lut_refill_irq
   import lut_refill_pkg::*;
#(
   parameter int N = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N-1:0][EV_W-1:0]   ev_i,
   input  logic                     clr_we_i,
   input  logic                     en_we_i,
   input  logic [31:0]              wdata_i,
   output logic [31:0]              stat_o,
   output logic [31:0]              en_o,
   output logic                     irq_o
);

   generate
      for (genvar n = 0; n < MAX_ENG; n++) begin : g_fld
         if (n < N) begin : g_on
            logic [EV_W-1:0] st_q;
            logic [7:0]      en_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  st_q <= '0;
                  en_q <= IEN_RESET;
               end else begin
                  st_q <= (clr_we_i ? (st_q & ~wdata_i[8*n +: EV_W]) : st_q) | ev_i[n];
                  if (en_we_i) en_q <= wdata_i[8*n +: 8];
               end
            end
            assign stat_o[8*n +: 8] = {{(8-EV_W){1'b0}}, st_q};
            assign en_o[8*n +: 8]   = en_q;
         end else begin : g_off
            assign stat_o[8*n +: 8] = 8'h00;
            assign en_o[8*n +: 8]   = 8'h00;
         end
      end
   endgenerate

   assign irq_o = |(stat_o & en_o);

endmodule

// File: rtl/lut_refill_dma.sv
module lut_refill_dma
   import lut_refill_pkg::*;
#(
   parameter int NUM_ENG = 2,
   parameter int NUM_LUT = 2,
   parameter int LUT_W   = 256,
   parameter int LUT_H   = 128,
   parameter int ADDR_W  = 32,
   localparam int XW     = (LUT_W > 1) ? $clog2(LUT_W) : 1,
   localparam int YW     = (LUT_H > 1) ? $clog2(LUT_H) : 1,
   localparam int LIDW   = (NUM_LUT > 1) ? $clog2(NUM_LUT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_rerr,
   output logic              lut_we,
   output logic [LIDW-1:0]   lut_sel,
   output logic [XW-1:0]     lut_x,
   output logic [YW-1:0]     lut_y,
   output logic [31:0]       lut_data,
   output logic              irq
);

   generate
      if (NUM_ENG < 1 || NUM_ENG > MAX_ENG) begin : g_bad_eng
         $error("NUM_ENG must be 1..4");
      end
      if (NUM_LUT < 1 || NUM_LUT > 31) begin : g_bad_lut
         $error("NUM_LUT must be 1..31");
      end
      if (XW > 8 || YW > 8) begin : g_bad_geom
         $error("table geometry exceeds 8-bit coordinates");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must be 8..32");
      end
   endgenerate

   localparam logic [31:0] HWINFO = {3'b0, 5'(NUM_ENG), 3'b0, 5'(NUM_LUT), 16'h0};

   logic [NUM_ENG-1:0]             want, grant, resp, start, abort;
   logic [NUM_ENG-1:0]             eng_ready, eng_fault, eng_we;
   logic [NUM_ENG-1:0][ADDR_W-1:0] eng_addr;
   logic [NUM_ENG-1:0][EV_W-1:0]   eng_ev;
   logic [NUM_ENG-1:0][LIDW-1:0]   eng_id;
   logic [NUM_ENG-1:0][XW-1:0]     eng_x;
   logic [NUM_ENG-1:0][YW-1:0]     eng_y;
   logic [NUM_ENG-1:0][31:0]       eng_data;
   logic [NUM_ENG-1:0][31:0]       desc_q;
   logic [31:0]                    irq_stat, irq_en;

   generate
      for (genvar n = 0; n < NUM_ENG; n++) begin : g_eng
         logic wr_desc;
         assign wr_desc  = cfg_we && (cfg_addr == {RG_DESC, 2'(n)});
         assign start[n] = wr_desc && (cfg_wdata != 32'd0);
         assign abort[n] = wr_desc && (cfg_wdata == 32'd0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       desc_q[n] <= '0;
            else if (wr_desc) desc_q[n] <= cfg_wdata;
         end

         lut_refill_walker #(
            .ADDR_W(ADDR_W), .LUT_W(LUT_W), .LUT_H(LUT_H), .NUM_LUT(NUM_LUT),
            .XW(XW), .YW(YW), .LIDW(LIDW)
         ) u_walk (
            .clk(clk), .rst_n(rst_n),
            .start_i(start[n]), .abort_i(abort[n]), .start_addr_i(cfg_wdata),
            .want_o(want[n]), .addr_o(eng_addr[n]), .grant_i(grant[n]),
            .rvalid_i(resp[n]), .rdata_i(mem_rdata), .rerr_i(mem_rerr),
            .ready_o(eng_ready[n]), .fault_o(eng_fault[n]), .ev_o(eng_ev[n]),
            .lut_we_o(eng_we[n]), .lut_id_o(eng_id[n]), .lut_x_o(eng_x[n]),
            .lut_y_o(eng_y[n]), .lut_data_o(eng_data[n])
         );
      end
   endgenerate

   lut_refill_arb #(.N(NUM_ENG), .ADDR_W(ADDR_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .want_i(want), .addr_i(eng_addr),
      .mem_rvalid_i(mem_rvalid), .grant_o(grant), .resp_o(resp),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr)
   );

   lut_refill_irq #(.N(NUM_ENG)) u_irq (
      .clk(clk), .rst_n(rst_n), .ev_i(eng_ev),
      .clr_we_i(cfg_we && cfg_addr == RA_ISTAT),
      .en_we_i(cfg_we && cfg_addr == RA_IEN),
      .wdata_i(cfg_wdata), .stat_o(irq_stat), .en_o(irq_en), .irq_o(irq)
   );

   // one response at a time, so at most one walker writes per cycle
   always_comb begin
      lut_we   = 1'b0;
      lut_sel  = '0;
      lut_x    = '0;
      lut_y    = '0;
      lut_data = '0;
      for (int n = 0; n < NUM_ENG; n++) begin
         if (eng_we[n]) begin
            lut_we   = 1'b1;
            lut_sel  = eng_id[n];
            lut_x    = eng_x[n];
            lut_y    = eng_y[n];
            lut_data = eng_data[n];
         end
      end
   end

   always_comb begin
      cfg_rdata = 32'd0;
      if (cfg_addr == RA_INFO)       cfg_rdata = HWINFO;
      else if (cfg_addr == RA_ISTAT) cfg_rdata = irq_stat;
      else if (cfg_addr == RA_IEN)   cfg_rdata = irq_en;
      else begin
         for (int n = 0; n < NUM_ENG; n++) begin
            if (cfg_addr == {RG_DESC, 2'(n)}) cfg_rdata = desc_q[n];
            if (cfg_addr == {RG_STAT, 2'(n)}) cfg_rdata = {30'd0, eng_fault[n], eng_ready[n]};
         end
      end
   end

endmodule

// File: rtl/lut_refill_chk.sv
module lut_refill_chk #(
   parameter int NUM_ENG = 2,
   parameter int ADDR_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [3:0]         cfg_addr,
   input logic [31:0]        cfg_wdata,
   input logic               mem_req,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               mem_rvalid,
   input logic               mem_rerr,
   input logic               lut_we,
   input logic [NUM_ENG-1:0] eng_ready,
   input logic [NUM_ENG-1:0] eng_fault,
   input logic [31:0]        irq_stat
);

   logic pend_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (mem_req)    pend_q <= 1'b1;
      else if (mem_rvalid) pend_q <= 1'b0;
   end

   // R12
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !pend_q);

   // R12
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   // R3
   write_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lut_we |-> (mem_rvalid && !mem_rerr && pend_q));

   generate
      for (genvar n = 0; n < NUM_ENG; n++) begin : g_c
         // R7
         fault_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(eng_fault[n]) |=> (irq_stat[8*n+2] || irq_stat[8*n+3]));

         // R9
         abort_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == 4'(4 + n) && cfg_wdata == 32'd0) |=> eng_ready[n]);

         // R9
         fault_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (eng_fault[n] && cfg_we && cfg_addr == 4'(4 + n) && cfg_wdata != 32'd0)
            |=> eng_fault[n]);
      end
   endgenerate

endmodule

bind lut_refill_dma lut_refill_chk #(.NUM_ENG(NUM_ENG), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
   .mem_rvalid(mem_rvalid), .mem_rerr(mem_rerr), .lut_we(lut_we),
   .eng_ready(eng_ready), .eng_fault(eng_fault), .irq_stat(irq_stat)
);

// File: tb/sim_lut_refill_dma.sv
`timescale 1ns/1ps
module sim_lut_refill_dma;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = 4'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [31:0] cfg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = 32'd0;
   logic        mem_rerr = 1'b0;
   logic        lut_we;
   logic [0:0]  lut_sel;
   logic [7:0]  lut_x;
   logic [6:0]  lut_y;
   logic [31:0] lut_data;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   lut_refill_dma u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .mem_rerr(mem_rerr), .lut_we(lut_we), .lut_sel(lut_sel), .lut_x(lut_x),
      .lut_y(lut_y), .lut_data(lut_data), .irq(irq)
   );

   // memory model: 1 KiB, two-cycle latency, error above 0x3FF
   logic [31:0] mem [256];
   logic [31:0] pa;
   int          pd;

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      mem_rerr   <= 1'b0;
      if (!rst_n) pd <= 0;
      else if (mem_req) begin
         pa <= mem_addr;
         pd <= 2;
      end else if (pd != 0) begin
         pd <= pd - 1;
         if (pd == 1) begin
            mem_rvalid <= 1'b1;
            if (pa >= 32'h400) begin
               mem_rerr  <= 1'b1;
               mem_rdata <= 32'hDEAD_BEEF;
            end else mem_rdata <= mem[pa[9:2]];
         end
      end
   end

   // table write log
   logic [7:0]  lx [64];
   logic [6:0]  ly [64];
   logic [0:0]  li [64];
   logic [31:0] ld [64];
   int          ncnt = 0;

   always @(posedge clk) begin
      if (lut_we) begin
         if (ncnt < 64) begin
            lx[ncnt] <= lut_x;
            ly[ncnt] <= lut_y;
            li[ncnt] <= lut_sel;
            ld[ncnt] <= lut_data;
         end
         ncnt <= ncnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] a, input logic [31:0] d);
      mem[a[9:2]] = d;
   endtask

   task automatic desc(input logic [31:0] a, input logic [31:0] nxt,
                       input logic [31:0] area, input logic [31:0] ctl,
                       input logic [31:0] dp);
      put(a, nxt); put(a + 4, area); put(a + 8, ctl); put(a + 12, dp);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_end(input int n);
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(4'(8 + n), s);
         if (s[1:0] != 2'b00) break;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic ent(input string tag, input int i, input logic [7:0] x,
                      input logic [6:0] y, input logic id, input logic [31:0] d);
      chk(tag, {15'd0, li[i], lx[i], 1'b0, ly[i]}, {15'd0, id, x, 1'b0, y});
      chk(tag, ld[i], d);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(4'd0, v); chk("R1 hwinfo", v, 32'h0202_0000);
      rd(4'd1, v); chk("R1 irq status", v, 32'h0);
      rd(4'd2, v); chk("R1 irq enable", v, 32'h0000_7E7E);
      rd(4'd8, v); chk("R1 status0", v, 32'h1);
      rd(4'd9, v); chk("R1 status1", v, 32'h1);
      chk("R1 irq line", {31'd0, irq}, 32'h0);
   endtask

   task automatic t_single();
      logic [31:0] v;
      int b;
      b = ncnt;
      wr(4'd4, 32'h040);
      wait_end(0);
      chk("R3 count", ncnt - b, 4);
      ent("R3 e0", b + 0, 3, 5, 0, 32'hA0);
      ent("R3 e1", b + 1, 4, 5, 0, 32'hA1);
      ent("R3 e2", b + 2, 3, 6, 0, 32'hA2);
      ent("R3 e3", b + 3, 4, 6, 0, 32'hA3);
      rd(4'd1, v); chk("R4 R5 irq field", v, 32'h3);
      chk("R11 irq high", {31'd0, irq}, 32'h1);
      rd(4'd8, v); chk("R4 ready again", v, 32'h1);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      wr(4'd1, 32'h2);
      rd(4'd1, v); chk("R10 clear last", v, 32'h1);
      chk("R11 fetched masked", {31'd0, irq}, 32'h0);
      wr(4'd1, 32'h1);
      rd(4'd1, v); chk("R10 clear all", v, 32'h0);
   endtask

   task automatic t_chain();
      logic [31:0] v;
      int b;
      b = ncnt;
      wr(4'd5, 32'h087);
      wait_end(1);
      chk("R4 chain count", ncnt - b, 4);
      ent("R2 R3 a0", b + 0, 10, 0, 1, 32'hB0);
      ent("R3 a1", b + 1, 11, 0, 1, 32'hB1);
      ent("R3 a2", b + 2, 12, 0, 1, 32'hB2);
      ent("R4 b0", b + 3, 0, 127, 0, 32'hB3);
      rd(4'd1, v); chk("R10 engine1 field", v, 32'h0000_0300);
      wr(4'd1, 32'hFFFF_FFFF);
   endtask

   task automatic t_skip();
      logic [31:0] v;
      int b;
      b = ncnt;
      wr(4'd4, 32'h1C0);
      wait_end(0);
      chk("R6 one write", ncnt - b, 1);
      ent("R6 entry", b, 1, 1, 0, 32'hA0);
      rd(4'd1, v); chk("R6 fetched+last", v, 32'h3);
      wr(4'd1, 32'hFFFF_FFFF);
   endtask

   task automatic t_both();
      logic [31:0] v;
      int b;
      b = ncnt;
      wr(4'd4, 32'h040);
      wr(4'd5, 32'h0C0);
      wait_end(0);
      wait_end(1);
      chk("R12 both count", ncnt - b, 5);
      ent("R12 first write", b, 3, 5, 0, 32'hA0);
      rd(4'd1, v); chk("R12 both done", v, 32'h0000_0303);
      wr(4'd2, 32'h0);
      chk("R11 all masked", {31'd0, irq}, 32'h0);
      rd(4'd2, v); chk("R11 enable readback", v, 32'h0);
      wr(4'd2, 32'h0000_0100);
      chk("R11 bit8 enabled", {31'd0, irq}, 32'h1);
      wr(4'd2, 32'h0000_7E7E);
      wr(4'd1, 32'hFFFF_FFFF);
   endtask

   task automatic t_range();
      logic [31:0] v;
      int b;
      b = ncnt;
      wr(4'd4, 32'h200);
      wait_end(0);
      rd(4'd8, v); chk("R7 fault status", v, 32'h2);
      rd(4'd1, v); chk("R7 range field", v, 32'h5);
      chk("R7 no writes", ncnt - b, 0);
      wr(4'd4, 32'h040);
      repeat (40) @(negedge clk);
      chk("R9 ignored start", ncnt - b, 0);
      rd(4'd8, v); chk("R9 still fault", v, 32'h2);
      wr(4'd4, 32'h0);
      rd(4'd8, v); chk("R9 cleared", v, 32'h1);
      wr(4'd1, 32'hFFFF_FFFF);
      b = ncnt;
      wr(4'd4, 32'h2C0);
      wait_end(0);
      rd(4'd1, v); chk("R7 bad table id", v, 32'h5);
      chk("R7 id no writes", ncnt - b, 0);
      wr(4'd4, 32'h0);
      wr(4'd1, 32'hFFFF_FFFF);
   endtask

   task automatic t_bus();
      logic [31:0] v;
      wr(4'd4, 32'h240);
      wait_end(0);
      rd(4'd8, v); chk("R8 fault status", v, 32'h2);
      rd(4'd1, v); chk("R8 bus field", v, 32'h9);
      wr(4'd4, 32'h0);
      wr(4'd1, 32'hFFFF_FFFF);
   endtask

   task automatic t_abort();
      logic [31:0] v;
      int b, m;
      b = ncnt;
      wr(4'd4, 32'h280);
      repeat (60) @(negedge clk);
      wr(4'd4, 32'h0);
      rd(4'd8, v); chk("R9 abort ready", v, 32'h1);
      repeat (4) @(negedge clk);
      m = ncnt - b;
      repeat (30) @(negedge clk);
      chk("R9 partial", {31'd0, (m > 0 && m < 128)}, 32'h1);
      chk("R9 stopped", ncnt - b, m);
      rd(4'd1, v); chk("R9 no last-done", v & 32'h2, 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h1000 + i;
      put(32'h100, 32'hA0); put(32'h104, 32'hA1);
      put(32'h108, 32'hA2); put(32'h10C, 32'hA3);
      put(32'h140, 32'hB0); put(32'h144, 32'hB1);
      put(32'h148, 32'hB2); put(32'h150, 32'hB3);
      desc(32'h040, 32'h0,   32'h0604_0503, 32'h001, 32'h100);
      desc(32'h080, 32'h0C0, 32'h000C_000A, 32'h101, 32'h140);
      desc(32'h0C0, 32'h0,   32'h7F00_7F00, 32'h001, 32'h150);
      desc(32'h1C0, 32'h1D0, 32'h0,         32'h000, 32'h100);
      desc(32'h1D0, 32'h0,   32'h0101_0101, 32'h001, 32'h100);
      desc(32'h200, 32'h0,   32'hC800_0000, 32'h001, 32'h100);
      desc(32'h2C0, 32'h0,   32'h0,         32'h201, 32'h100);
      desc(32'h240, 32'h0,   32'h0,         32'h001, 32'h800);
      desc(32'h280, 32'h0,   32'h013F_0000, 32'h001, 32'h000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_w1c();
      t_chain();
      t_skip();
      t_both();
      t_range();
      t_bus();
      t_abort();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule